// File: doc/BRIEF.md
# Serial Controller Register Sequencer

This block is the host-side register front end of an asynchronous serial controller. A two-location host bus reaches it, with one address bit choosing between the data location and the control/status location. A single control location takes on different meanings over time. After reset, the first control write configures the line format. If that format selects synchronous operation, the next two control writes supply a pair of sync characters. Every control write after that is a command. A command bit can send the sequence back to waiting for a format word.

The block holds the format, sync and command words and trims transmit data to the configured character length. It keeps the transmit and receive handshake flags and the receive error flags. It drives one-cycle strobes to a separate shifter, telling it to start, abort or report readiness, and it drives level outputs for receiver enable and break. The shifter reports completion and received characters back through dedicated inputs.

Top module: `usart_cfg_seq`

## Requirements
- R1: After reset, a status read (busAddr=1) returns 0x04. Status bit positions are TXRDY=0, RXRDY=1, TXEMPTY=2, PE=3, OE=4, FE=5, and bits 7:6 are zero. rxEnable and sendBreak are 0, and the next control write is taken as the format word.
- R2: A format word whose bits [1:0] are 00 selects synchronous operation. The next two control writes are stored as syncWord1 and then syncWord2, and only after that does a control write become a command. Any other value of bits [1:0] makes the very next control write a command.
- R3: Format bits [3:2] choose the character length, 0..3 giving 5..8 bits. Data written to busAddr=0 is ANDed with the matching mask (0x1F, 0x3F, 0x7F, 0xFF) before it appears on txData.
- R4: A command with bit 6 set returns the sequencer to waiting for a format word.
- R5: A command with bit 4 set clears PE, OE and FE. An error reported by rxValid in that same cycle still sets its flag.
- R6: A data write made after the sequence reaches the command stage, while command bit 0 (transmit enable) is 1, pulses txStart for one cycle and clears TXRDY and TXEMPTY. A data write made earlier only updates txData and does not pulse txStart.
- R7: Writing a command with bit 0 set while TXEMPTY=1 sets TXRDY and pulses txIrq. Writing it while TXEMPTY=0 pulses txStart again to resume the pending character.
- R8: Writing a command with bit 0 clear clears TXRDY. If TXEMPTY=0 at that point, txAbort pulses.
- R9: txDone sets TXRDY and TXEMPTY. A transmit-starting data write in the same cycle takes precedence and leaves both clear.
- R10: rxValid loads rxData into the receive buffer and sets RXRDY. rxParityErr and rxFrameErr set PE and FE. OE is set when RXRDY was already 1 and no data read happens in that cycle.
- R11: A data read (busRdEn with busAddr=0) returns the receive buffer and clears RXRDY, unless rxValid arrives in the same cycle, in which case RXRDY stays 1.
- R12: rxEnable follows command bit 2 and sendBreak follows command bit 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Host write strobe |
| busRdEn | input | 1 | Host read strobe |
| busAddr | input | 1 | 0 selects data, 1 selects control/status |
| busWrData | input | 8 | Host write data |
| busRdData | output | 8 | Receive buffer or status byte |
| modeWord | output | 8 | Stored format word |
| syncWord1 | output | 8 | First sync character |
| syncWord2 | output | 8 | Second sync character |
| cmdWord | output | 8 | Stored command word |
| txData | output | 8 | Masked transmit character |
| txStart | output | 1 | One-cycle start request to the shifter |
| txAbort | output | 1 | One-cycle abort request to the shifter |
| txIrq | output | 1 | One-cycle transmitter-ready interrupt |
| txDone | input | 1 | Shifter finished a character |
| rxEnable | output | 1 | Receive path enable level |
| sendBreak | output | 1 | Break level on the line |
| rxValid | input | 1 | Received character valid |
| rxData | input | 8 | Received character |
| rxParityErr | input | 1 | Parity error with rxValid |
| rxFrameErr | input | 1 | Framing error with rxValid |

## Verification
Two pairs of events can collide in one cycle, and both are driven together on purpose. The first pair is a transmit-starting data write and the shifter's txDone. The bench drives both in the same cycle and expects TXEMPTY and TXRDY to read back clear while txStart still pulses. The second pair is a host data read and an incoming rxValid. The read must return the older character, RXRDY must stay set and OE must stay clear; a following read must then return the newer character.

// File: rtl/usart_cfg_pkg.sv
package usart_cfg_pkg;

  typedef enum logic [1:0] {
    SEQ_MODE  = 2'd0,
    SEQ_SYNC1 = 2'd1,
    SEQ_SYNC2 = 2'd2,
    SEQ_CMD   = 2'd3
  } seq_e;

  typedef struct packed {
    logic modeWr;
    logic sync1Wr;
    logic sync2Wr;
    logic cmdWr;
    logic dataWr;
    logic dataRd;
    logic txLoad;
    logic txResume;
    logic txArm;
    logic txHalt;
    logic errClr;
  } strobe_t;

  localparam int CMD_TXEN = 0;
  localparam int CMD_RXE  = 2;
  localparam int CMD_SBRK = 3;
  localparam int CMD_ER   = 4;
  localparam int CMD_IR   = 6;
  localparam int MIN_CHAR = 5;

endpackage

// File: rtl/usart_cfg_ctrl.sv
module usart_cfg_ctrl
  import usart_cfg_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    busWrEn,
  input  logic    busRdEn,
  input  logic    busAddr,
  input  logic    wrTxEn,
  input  logic    wrErrRst,
  input  logic    wrIntRst,
  input  logic    wrSyncSel,
  input  logic    txEmpty,
  output strobe_t strb
);

  seq_e seqState, seqNext;
  logic ctlWr, dataWr;

  assign ctlWr  = busWrEn & busAddr;
  assign dataWr = busWrEn & ~busAddr;

  always_comb begin
    strb          = '0;
    strb.modeWr   = ctlWr & (seqState == SEQ_MODE);
    strb.sync1Wr  = ctlWr & (seqState == SEQ_SYNC1);
    strb.sync2Wr  = ctlWr & (seqState == SEQ_SYNC2);
    strb.cmdWr    = ctlWr & (seqState == SEQ_CMD);
    strb.dataWr   = dataWr;
    strb.dataRd   = busRdEn & ~busAddr;
    strb.txLoad   = dataWr & (seqState == SEQ_CMD) & cmdTxEnQ;
    strb.txResume = strb.cmdWr & wrTxEn & ~txEmpty;
    strb.txArm    = strb.cmdWr & wrTxEn & txEmpty;
    strb.txHalt   = strb.cmdWr & ~wrTxEn;
    strb.errClr   = strb.cmdWr & wrErrRst;
  end

  // local copy of the transmit-enable command bit
  logic cmdTxEnQ;
  always_ff @(posedge clk) begin
    if (!rstN)           cmdTxEnQ <= 1'b0;
    else if (strb.cmdWr) cmdTxEnQ <= wrTxEn;
  end

  always_comb begin
    seqNext = seqState;
    unique case (seqState)
      SEQ_MODE:  if (ctlWr) seqNext = wrSyncSel ? SEQ_SYNC1 : SEQ_CMD;
      SEQ_SYNC1: if (ctlWr) seqNext = SEQ_SYNC2;
      SEQ_SYNC2: if (ctlWr) seqNext = SEQ_CMD;
      SEQ_CMD:   if (ctlWr && wrIntRst) seqNext = SEQ_MODE;
      default:   seqNext = SEQ_MODE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) seqState <= SEQ_MODE;
    else       seqState <= seqNext;
  end

  a_r2_async_to_cmd: assert property (@(posedge clk) disable iff (!rstN)
    (strb.modeWr && !wrSyncSel) |=> (seqState == SEQ_CMD));
  a_r2_sync_chain: assert property (@(posedge clk) disable iff (!rstN)
    strb.sync1Wr |=> (seqState == SEQ_SYNC2));
  a_r4_ir_to_mode: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmdWr && wrIntRst) |=> (seqState == SEQ_MODE));
  a_r6_one_role: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.modeWr, strb.sync1Wr, strb.sync2Wr, strb.cmdWr, strb.dataWr}));

endmodule

// File: rtl/usart_cfg_dp.sv
module usart_cfg_dp
  import usart_cfg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [DATA_W-1:0] modeWord,
  output logic [DATA_W-1:0] syncWord1,
  output logic [DATA_W-1:0] syncWord2,
  output logic [DATA_W-1:0] cmdWord,
  output logic [DATA_W-1:0] txData,
  output logic              txStart,
  output logic              txAbort,
  output logic              txIrq,
  output logic              txEmpty,
  input  logic              txDone,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxParityErr,
  input  logic              rxFrameErr
);

  localparam int STAT_PAD = DATA_W - 6;

  logic [DATA_W-1:0] charMask, rxBuf, statusByte;
  logic [1:0]        lenSel;
  logic              txRdy, rxRdy, perr, oerr, ferr;

  assign lenSel   = modeWord[3:2];
  assign charMask = DATA_W'((64'd1 << (MIN_CHAR + int'(lenSel))) - 64'd1);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      modeWord  <= '0;
      syncWord1 <= '0;
      syncWord2 <= '0;
      cmdWord   <= '0;
      txData    <= '0;
    end else begin
      if (strb.modeWr)  modeWord  <= busWrData;
      if (strb.sync1Wr) syncWord1 <= busWrData;
      if (strb.sync2Wr) syncWord2 <= busWrData;
      if (strb.cmdWr)   cmdWord   <= busWrData;
      if (strb.dataWr)  txData    <= busWrData & charMask;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txRdy   <= 1'b0;
      txEmpty <= 1'b1;
      txStart <= 1'b0;
      txAbort <= 1'b0;
      txIrq   <= 1'b0;
    end else begin
      txStart <= strb.txLoad | strb.txResume;
      txAbort <= strb.txHalt & ~txEmpty;
      txIrq   <= strb.txArm;
      if (strb.txLoad)                txRdy <= 1'b0;
      else if (strb.txHalt)           txRdy <= 1'b0;
      else if (strb.txArm || txDone)  txRdy <= 1'b1;
      if (strb.txLoad)                txEmpty <= 1'b0;
      else if (txDone)                txEmpty <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxBuf <= '0;
      rxRdy <= 1'b0;
      perr  <= 1'b0;
      oerr  <= 1'b0;
      ferr  <= 1'b0;
    end else begin
      if (rxValid) rxBuf <= rxData;
      if (rxValid)          rxRdy <= 1'b1;
      else if (strb.dataRd) rxRdy <= 1'b0;
      if (rxValid && rxParityErr) perr <= 1'b1;
      else if (strb.errClr)       perr <= 1'b0;
      if (rxValid && rxFrameErr)  ferr <= 1'b1;
      else if (strb.errClr)       ferr <= 1'b0;
      if (rxValid && rxRdy && !strb.dataRd) oerr <= 1'b1;
      else if (strb.errClr)                 oerr <= 1'b0;
    end
  end

  assign statusByte = {{STAT_PAD{1'b0}}, ferr, oerr, perr, txEmpty, rxRdy, txRdy};
  assign busRdData  = busAddr ? statusByte : rxBuf;

  a_r6_load_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.txLoad |=> (!txEmpty && !txRdy && txStart));
  a_r9_done_sets: assert property (@(posedge clk) disable iff (!rstN)
    (txDone && !strb.txLoad) |=> txEmpty);
  a_r8_halt_clears: assert property (@(posedge clk) disable iff (!rstN)
    strb.txHalt |=> !txRdy);
  a_r11_read_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strb.dataRd && !rxValid) |=> !rxRdy);
  a_r10_overrun: assert property (@(posedge clk) disable iff (!rstN)
    (rxValid && rxRdy && !strb.dataRd) |=> oerr);
  a_r5_err_clear: assert property (@(posedge clk) disable iff (!rstN)
    (strb.errClr && !rxValid) |=> (!perr && !oerr && !ferr));
  a_r3_masked: assert property (@(posedge clk) disable iff (!rstN)
    strb.dataWr |=> ((txData & ~charMask) == '0));

endmodule

// File: rtl/usart_cfg_seq.sv
module usart_cfg_seq
  import usart_cfg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic              busAddr,
  input  logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] busRdData,
  output logic [DATA_W-1:0] modeWord,
  output logic [DATA_W-1:0] syncWord1,
  output logic [DATA_W-1:0] syncWord2,
  output logic [DATA_W-1:0] cmdWord,
  output logic [DATA_W-1:0] txData,
  output logic              txStart,
  output logic              txAbort,
  output logic              txIrq,
  input  logic              txDone,
  output logic              rxEnable,
  output logic              sendBreak,
  input  logic              rxValid,
  input  logic [DATA_W-1:0] rxData,
  input  logic              rxParityErr,
  input  logic              rxFrameErr
);

  strobe_t strb;
  logic    txEmpty;

  usart_cfg_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busAddr   (busAddr),
    .wrTxEn    (busWrData[CMD_TXEN]),
    .wrErrRst  (busWrData[CMD_ER]),
    .wrIntRst  (busWrData[CMD_IR]),
    .wrSyncSel (busWrData[1:0] == 2'b00),
    .txEmpty   (txEmpty),
    .strb      (strb)
  );

  usart_cfg_dp #(.DATA_W(DATA_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .busAddr     (busAddr),
    .busWrData   (busWrData),
    .busRdData   (busRdData),
    .modeWord    (modeWord),
    .syncWord1   (syncWord1),
    .syncWord2   (syncWord2),
    .cmdWord     (cmdWord),
    .txData      (txData),
    .txStart     (txStart),
    .txAbort     (txAbort),
    .txIrq       (txIrq),
    .txEmpty     (txEmpty),
    .txDone      (txDone),
    .rxValid     (rxValid),
    .rxData      (rxData),
    .rxParityErr (rxParityErr),
    .rxFrameErr  (rxFrameErr)
  );

  assign rxEnable  = cmdWord[CMD_RXE];
  assign sendBreak = cmdWord[CMD_SBRK];

  a_r12_levels: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cmdWr) |=> (rxEnable == $past(busWrData[CMD_RXE]) &&
                      sendBreak == $past(busWrData[CMD_SBRK])));

endmodule

// File: tb/usart_cfg_seq_tb.sv
module usart_cfg_seq_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       busWrEn = 1'b0, busRdEn = 1'b0, busAddr = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData, modeWord, syncWord1, syncWord2, cmdWord, txData;
  logic       txStart, txAbort, txIrq, rxEnable, sendBreak;
  logic       txDone = 1'b0, rxValid = 1'b0, rxParityErr = 1'b0, rxFrameErr = 1'b0;
  logic [7:0] rxData = '0;

  int checks = 0;
  int failures = 0;
  logic sStart, sAbort, sIrq;

  always #4 clk = ~clk;

  usart_cfg_seq u_dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .modeWord(modeWord), .syncWord1(syncWord1), .syncWord2(syncWord2),
    .cmdWord(cmdWord), .txData(txData), .txStart(txStart), .txAbort(txAbort),
    .txIrq(txIrq), .txDone(txDone), .rxEnable(rxEnable), .sendBreak(sendBreak),
    .rxValid(rxValid), .rxData(rxData), .rxParityErr(rxParityErr),
    .rxFrameErr(rxFrameErr)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic busWr(input logic addr, input logic [7:0] data, input logic done = 1'b0);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = addr; busWrData = data; txDone = done;
    @(negedge clk);
    sStart = txStart; sAbort = txAbort; sIrq = txIrq;
    busWrEn = 1'b0; txDone = 1'b0;
  endtask

  task automatic busRd(input logic addr, output logic [7:0] data, input logic rxAlso = 1'b0,
                       input logic [7:0] rxByte = 8'h00);
    @(negedge clk);
    busRdEn = 1'b1; busAddr = addr; rxValid = rxAlso; rxData = rxByte;
    #1 data = busRdData;
    @(negedge clk);
    busRdEn = 1'b0; rxValid = 1'b0;
  endtask

  task automatic rxPut(input logic [7:0] b, input logic pe = 1'b0, input logic fe = 1'b0);
    @(negedge clk);
    rxValid = 1'b1; rxData = b; rxParityErr = pe; rxFrameErr = fe;
    @(negedge clk);
    rxValid = 1'b0; rxParityErr = 1'b0; rxFrameErr = 1'b0;
  endtask

  task automatic pulseDone();
    @(negedge clk); txDone = 1'b1;
    @(negedge clk); txDone = 1'b0;
  endtask

  task automatic t_reset();
    logic [7:0] st;
    busRd(1'b1, st);
    chk(st == 8'h04, "R1 reset status", st, 8'h04);
    chk(!rxEnable && !sendBreak, "R1 reset levels", {rxEnable, sendBreak}, 0);
  endtask

  task automatic t_async();
    logic [7:0] st;
    busWr(1'b1, 8'h4E);
    chk(modeWord == 8'h4E, "R2 mode stored", modeWord, 8'h4E);
    busWr(1'b1, 8'h05);
    chk(cmdWord == 8'h05, "R2 async next is command", cmdWord, 8'h05);
    chk(rxEnable == 1'b1, "R12 rxEnable", rxEnable, 1);
    chk(sIrq == 1'b1, "R7 txIrq on enable", sIrq, 1);
    busRd(1'b1, st);
    chk(st == 8'h05, "R7 TXRDY set", st, 8'h05);
  endtask

  task automatic t_txMask();
    logic [7:0] st;
    busWr(1'b0, 8'hA5);
    chk(sStart && txData == 8'hA5, "R6 start 8-bit", {sStart, txData}, {1'b1, 8'hA5});
    busRd(1'b1, st);
    chk(st == 8'h00, "R6 tx flags cleared", st, 8'h00);
    pulseDone();
    busRd(1'b1, st);
    chk(st == 8'h05, "R9 done sets flags", st, 8'h05);
    busWr(1'b1, 8'h40);
    chk(!rxEnable, "R12 rxEnable off", rxEnable, 0);
    busWr(1'b1, 8'h42);
    chk(modeWord == 8'h42, "R4 reset to mode", modeWord, 8'h42);
    busWr(1'b1, 8'h01);
    busWr(1'b0, 8'hFF);
    chk(txData == 8'h1F, "R3 5-bit mask", txData, 8'h1F);
    pulseDone();
    busWr(1'b1, 8'h41);
    busWr(1'b1, 8'h46);
    busWr(1'b1, 8'h01);
    busWr(1'b0, 8'hFF);
    chk(txData == 8'h3F, "R3 6-bit mask", txData, 8'h3F);
    pulseDone();
  endtask

  task automatic t_sync();
    busWr(1'b1, 8'h41);
    busWr(1'b1, 8'h0C);
    busWr(1'b0, 8'h33);
    chk(!sStart && txData == 8'h33, "R6 pre-init no start", {sStart, txData}, {1'b0, 8'h33});
    busWr(1'b1, 8'h16);
    busWr(1'b1, 8'h27);
    chk(syncWord1 == 8'h16 && syncWord2 == 8'h27 && modeWord == 8'h0C,
        "R2 sync pair", {syncWord1, syncWord2}, 16'h1627);
    busWr(1'b1, 8'h09);
    chk(cmdWord == 8'h09 && sendBreak, "R12 sendBreak", {cmdWord, sendBreak}, {8'h09, 1'b1});
  endtask

  task automatic t_disable();
    logic [7:0] st;
    busWr(1'b0, 8'h3C);
    chk(sStart == 1'b1, "R6 start after sync", sStart, 1);
    busWr(1'b1, 8'h00);
    chk(sAbort == 1'b1, "R8 abort pulse", sAbort, 1);
    busRd(1'b1, st);
    chk((st & 8'h05) == 8'h00, "R8 TXRDY clear", st, 8'h00);
    busWr(1'b1, 8'h01);
    chk(sStart && !sIrq, "R7 resume pending", {sStart, sIrq}, 2'b10);
    busWr(1'b0, 8'h77, 1'b1);
    busRd(1'b1, st);
    chk(sStart && (st & 8'h05) == 8'h00, "R9 write beats done", st, 8'h00);
    pulseDone();
    busRd(1'b1, st);
    chk((st & 8'h05) == 8'h05, "R9 done after collision", st, 8'h05);
  endtask

  task automatic t_rx();
    logic [7:0] st, d;
    rxPut(8'h5A);
    busRd(1'b1, st);
    chk(st[1] == 1'b1, "R10 RXRDY set", st, 8'h02);
    busRd(1'b0, d);
    chk(d == 8'h5A, "R11 read data", d, 8'h5A);
    busRd(1'b1, st);
    chk(st[1] == 1'b0, "R11 RXRDY cleared", st[1], 0);
    rxPut(8'h11);
    rxPut(8'h22);
    busRd(1'b1, st);
    chk(st[4] == 1'b1, "R10 overrun", st[4], 1);
    busRd(1'b0, d);
    chk(d == 8'h22, "R10 newest kept", d, 8'h22);
    rxPut(8'h33, 1'b1, 1'b0);
    busRd(1'b1, st);
    chk(st[3] == 1'b1, "R10 parity flag", st[3], 1);
    busWr(1'b1, 8'h11);
    busRd(1'b1, st);
    chk(st[5:3] == 3'b000, "R5 errors cleared", st[5:3], 0);
    busRd(1'b0, d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = 1'b1; busWrData = 8'h11;
    rxValid = 1'b1; rxData = 8'h66; rxFrameErr = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; rxValid = 1'b0; rxFrameErr = 1'b0;
    busRd(1'b1, st);
    chk(st[5:3] == 3'b100, "R5 new error wins", st[5:3], 3'b100);
    busRd(1'b0, d);
    rxPut(8'h44);
    busRd(1'b0, d, 1'b1, 8'h55);
    chk(d == 8'h44, "R11 collision returns older", d, 8'h44);
    busRd(1'b1, st);
    chk(st[1] && !st[4], "R11 RXRDY kept, no overrun", st, 8'h02);
    busRd(1'b0, d);
    chk(d == 8'h55, "R10 newer buffered", d, 8'h55);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=0x0 expected=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    t_reset();
    t_async();
    t_txMask();
    t_sync();
    t_disable();
    t_rx();
    repeat (2) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule